// File: doc/BRIEF.md
# Paced Output Buffer with Dummy Fill

This block sits between an internal result producer and an external reader. The producer writes result words into an internal buffer. Words leave the block only when the outside asks for them. Each external request names a word count. A fixed number of cycles after the request is taken, the block sends exactly that many words, one every fixed number of cycles. When a slot comes up and the buffer holds nothing, the block sends a fixed dummy word in that slot. An outside observer therefore sees a timing pattern that depends only on the requests, never on how full the buffer is.

Every emitted word carries a real/dummy tag. A later encryption stage can use it to make the two kinds look alike. The producer sees a full flag and an occupancy count, and it must stall while the buffer is full. Requests that arrive while an earlier one is still being served wait in a short request queue. They are served in order. Each one keeps its own start delay, counted from the cycle it was taken.

Top module: `paced_out_fifo`

## Requirements
- R1: After reset, `out_valid_o`=0, `occ_o`=0, `full_o`=0 and `req_ready_o`=1.
- R2: A request with size Z≥1 produces exactly Z cycles with `out_valid_o`=1.
- R3: If a request is taken at clock edge t and nothing is being served, its first word is visible right after edge t+DELAY.
- R4: Consecutive words of one request, and consecutive words across queued requests, are exactly PERIOD cycles apart.
- R5: A slot that finds the buffer empty shows `out_real_o`=0 and `out_data_o`=DUMMY_WORD.
- R6: Real words leave in push order with `out_real_o`=1.
- R7: `full_o`=1 exactly when `occ_o`=DEPTH. A push while full is dropped, and the buffer never holds more than DEPTH words.
- R8: `occ_o` equals pushes taken minus words popped, where a pop happens in every slot whose buffer is not empty.
- R9: Requests are served in acceptance order. Each one starts at the later of (its acceptance edge + DELAY) and (previous request's last word + PERIOD).
- R10: A request with size 0 is ignored: it is not queued and produces no words.
- R11: `req_ready_o`=0 while REQ_SLOTS requests are waiting. A request presented then is dropped.
- R12: For the same request sequence, the cycles in which `out_valid_o` is high are identical whether the buffer is empty or full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Producer writes `push_data_i` this cycle |
| push_data_i | input | DATA_W | Result word to buffer |
| full_o | output | 1 | Buffer holds DEPTH words |
| occ_o | output | $clog2(DEPTH+1) | Words currently buffered |
| req_valid_i | input | 1 | Output request present |
| req_size_i | input | Z_W | Number of words requested |
| req_ready_o | output | 1 | Request queue can take a request |
| out_valid_o | output | 1 | An output slot is active this cycle |
| out_data_o | output | DATA_W | Real word or DUMMY_WORD |
| out_real_o | output | 1 | 1 for real data, 0 for dummy |

## Verification
The buffer is loaded partly, not at all and to the limit before requests are issued. This shows that real words come out first and dummy words fill the rest, and that pushes beyond capacity are lost. Back-to-back requests show how a queued request's own delay interacts with the end of the one ahead of it. A burst larger than the request queue exposes the refusal path, and a zero-size request confirms nothing is emitted. Finally, the same request is issued once with an empty buffer and once with a full one, and the two valid patterns are compared to show that timing does not depend on fill level.

// File: rtl/pofifo_pkg.sv
package pofifo_pkg;
  typedef enum logic {
    KIND_DUMMY = 1'b0,
    KIND_REAL  = 1'b1
  } word_kind_e;
endpackage

// File: rtl/pofifo_data_buf.sv
module pofifo_data_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DATA_W-1:0]            push_data_i,
  input  logic                         pop_i,
  output logic [DATA_W-1:0]            head_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   occ_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH+1);
  localparam logic [OCC_W-1:0] DEPTH_C = OCC_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  occ_q;
  logic              push_ok, pop_ok;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH-1)) ? '0 : i + IDX_W'(1);
  endfunction

  assign full_o  = (occ_q == DEPTH_C);
  assign empty_o = (occ_q == '0);
  assign occ_o   = occ_q;
  assign head_o  = mem_q[rd_q];
  assign push_ok = push_i && !full_o;  // full: push dropped
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= DEPTH_C);
  a_r7_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(occ_q));
  a_r8_occ_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (occ_q == $past(occ_q) || occ_q == $past(occ_q) + OCC_W'(1) ||
              occ_q + OCC_W'(1) == $past(occ_q)));
endmodule

// File: rtl/pofifo_req_queue.sv
module pofifo_req_queue #(
  parameter int Z_W   = 4,
  parameter int SLOTS = 4,
  parameter int DELAY = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_i,
  input  logic [Z_W-1:0] size_i,
  input  logic           pop_i,
  output logic           ready_o,
  output logic           head_due_o,
  output logic [Z_W-1:0] head_size_o
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS+1);
  localparam int CD_W  = $clog2(DELAY+1);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  logic [Z_W-1:0]   size_q [SLOTS];
  logic [CD_W-1:0]  cd_q   [SLOTS];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take, drop;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(SLOTS-1)) ? '0 : i + IDX_W'(1);
  endfunction

  assign ready_o     = (cnt_q != SLOTS_C);
  assign take        = acc_i && ready_o && (size_i != '0);  // size 0 ignored
  assign drop        = pop_i && (cnt_q != '0);
  assign head_due_o  = (cnt_q != '0) && (cd_q[rd_q] == '0);
  assign head_size_o = size_q[rd_q];

  // one delay counter per slot, started when the slot is written
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cd_q[g]   <= '0;
        size_q[g] <= '0;
      end else if (take && wr_q == IDX_W'(g)) begin
        cd_q[g]   <= CD_W'(DELAY-1);
        size_q[g] <= size_i;
      end else if (cd_q[g] != '0) begin
        cd_q[g]   <= cd_q[g] - CD_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (take) wr_q <= nxt(wr_q);
      if (drop) rd_q <= nxt(rd_q);
      case ({take, drop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r11_full_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SLOTS_C && !pop_i) |=> cnt_q == SLOTS_C);
  a_r10_zero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && size_i == '0 && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pofifo_pacer.sv
module pofifo_pacer #(
  parameter int Z_W    = 4,
  parameter int PERIOD = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           head_due_i,
  input  logic [Z_W-1:0] head_size_i,
  output logic           start_o,
  output logic           emit_o
);
  localparam int PACE_W = $clog2(PERIOD+1);

  logic [Z_W-1:0]    rem_q;
  logic [PACE_W-1:0] pace_q;
  logic              idle, cont;

  assign idle    = (rem_q == '0) && (pace_q == '0);
  assign start_o = idle && head_due_i;
  assign cont    = (pace_q == '0) && (rem_q != '0);
  assign emit_o  = start_o || cont;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      pace_q <= '0;
    end else if (start_o) begin
      rem_q  <= head_size_i - Z_W'(1);
      pace_q <= PACE_W'(PERIOD-1);
    end else if (cont) begin
      rem_q  <= rem_q - Z_W'(1);
      pace_q <= PACE_W'(PERIOD-1);
    end else if (pace_q != '0) begin
      pace_q <= pace_q - PACE_W'(1);
    end
  end

  if (PERIOD > 1) begin : g_gap_chk
    a_r4_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      emit_o |=> !emit_o);
  end
endmodule

// File: rtl/paced_out_fifo.sv
module paced_out_fifo
  import pofifo_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              DEPTH      = 8,
  parameter int              Z_W        = 4,
  parameter int              REQ_SLOTS  = 4,
  parameter int              DELAY      = 5,
  parameter int              PERIOD     = 3,
  parameter logic [DATA_W-1:0] DUMMY_WORD = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_valid_i,
  input  logic [DATA_W-1:0]           push_data_i,
  output logic                        full_o,
  output logic [$clog2(DEPTH+1)-1:0]  occ_o,
  input  logic                        req_valid_i,
  input  logic [Z_W-1:0]              req_size_i,
  output logic                        req_ready_o,
  output logic                        out_valid_o,
  output logic [DATA_W-1:0]           out_data_o,
  output logic                        out_real_o
);
  logic              emit, start, head_due, buf_empty;
  logic [Z_W-1:0]    head_size;
  logic [DATA_W-1:0] buf_head;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  word_kind_e        kind_q;

  pofifo_data_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .push_i(push_valid_i), .push_data_i,
    .pop_i(emit), .head_o(buf_head), .empty_o(buf_empty),
    .full_o, .occ_o
  );

  pofifo_req_queue #(.Z_W(Z_W), .SLOTS(REQ_SLOTS), .DELAY(DELAY)) u_rq (
    .clk_i, .rst_ni,
    .acc_i(req_valid_i), .size_i(req_size_i), .pop_i(start),
    .ready_o(req_ready_o), .head_due_o(head_due), .head_size_o(head_size)
  );

  pofifo_pacer #(.Z_W(Z_W), .PERIOD(PERIOD)) u_pace (
    .clk_i, .rst_ni,
    .head_due_i(head_due), .head_size_i(head_size),
    .start_o(start), .emit_o(emit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      kind_q  <= KIND_DUMMY;
    end else begin
      valid_q <= emit;
      if (emit && !buf_empty) begin
        data_q <= buf_head;
        kind_q <= KIND_REAL;
      end else begin
        data_q <= DUMMY_WORD;  // dummy also when idle
        kind_q <= KIND_DUMMY;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_real_o  = (kind_q == KIND_REAL);

  a_r5_dummy_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_real_o) |-> out_data_o == DUMMY_WORD);
  a_r6_real_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && buf_empty) |=> !out_real_o);
endmodule

// File: tb/tb_paced_out_fifo.sv
module tb_paced_out_fifo;
  localparam int DATA_W = 16, DEPTH = 8, Z_W = 4, REQ_SLOTS = 4, DELAY = 5, PERIOD = 3;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, req_valid = 0;
  logic [DATA_W-1:0] push_data = '0;
  logic [Z_W-1:0] req_size = '0;
  logic full, req_ready, out_valid, out_real;
  logic [$clog2(DEPTH+1)-1:0] occ;
  logic [DATA_W-1:0] out_data;

  always #5 clk = ~clk;

  paced_out_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .Z_W(Z_W), .REQ_SLOTS(REQ_SLOTS),
                   .DELAY(DELAY), .PERIOD(PERIOD), .DUMMY_WORD('0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_data_i(push_data),
    .full_o(full), .occ_o(occ), .req_valid_i(req_valid), .req_size_i(req_size),
    .req_ready_o(req_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_real_o(out_real));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int mq[$]; int rq_sz[$]; int rq_acc[$];
  int rem = 0, next_emit = 0;
  bit e_valid = 0, e_real = 0, e_full = 0, e_ready = 1;
  int e_data = 0, e_occ = 0;

  always @(posedge clk) begin
    int sz0, rc0;
    bit emit;
    cyc++;
    if (!rst_n) begin
      mq.delete(); rq_sz.delete(); rq_acc.delete();
      rem = 0; next_emit = 0;
      e_valid = 0; e_real = 0; e_data = 0; e_occ = 0; e_full = 0; e_ready = 1;
    end else begin
      sz0 = mq.size(); rc0 = rq_sz.size(); emit = 0;
      if (rem > 0 && cyc >= next_emit) begin
        emit = 1; rem--; next_emit = cyc + PERIOD;
      end else if (rem == 0 && cyc >= next_emit && rq_sz.size() > 0 &&
                   cyc >= rq_acc[0] + DELAY) begin
        emit = 1; rem = rq_sz.pop_front() - 1; void'(rq_acc.pop_front());
        next_emit = cyc + PERIOD;
      end
      e_valid = emit; e_real = 0; e_data = 0;
      if (emit && mq.size() > 0) begin e_real = 1; e_data = mq.pop_front(); end
      if (push_valid && sz0 < DEPTH) mq.push_back(int'(push_data));
      if (req_valid && req_size != 0 && rc0 < REQ_SLOTS) begin
        rq_sz.push_back(int'(req_size)); rq_acc.push_back(cyc);
      end
      e_occ = mq.size(); e_full = (e_occ == DEPTH); e_ready = (rq_sz.size() < REQ_SLOTS);
    end
  end

  int vt[$]; int vd[$]; int vr[$];
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == e_valid, "R3/R4/R9 out_valid", out_valid, e_valid);
      chk(out_real == e_real, "R5/R6 out_real", out_real, e_real);
      chk(int'(out_data) == e_data, "R5/R6 out_data", out_data, e_data);
      chk(int'(occ) == e_occ, "R8 occ", occ, e_occ);
      chk(full == e_full, "R7 full", full, e_full);
      chk(req_ready == e_ready, "R11 req_ready", req_ready, e_ready);
      if (out_valid) begin vt.push_back(cyc); vd.push_back(int'(out_data)); vr.push_back(out_real); end
    end
  end

  task automatic push(int d);
    push_valid = 1; push_data = DATA_W'(d);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic req(int z, output int acc);
    req_valid = 1; req_size = Z_W'(z); acc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic clr();
    vt.delete(); vd.delete(); vr.delete();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int acc, acc2;
    int rel0[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(occ == 0, "R1 occ", occ, 0);
    chk(full == 0, "R1 full", full, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);

    // partial fill: 3 real then 2 dummy
    clr();
    for (int i = 0; i < 3; i++) push(16'hA001 + i);
    req(5, acc);
    repeat (40) @(negedge clk);
    chk(vt.size() == 5, "R2 word count", vt.size(), 5);
    chk(vt[0] - acc == DELAY, "R3 first word delay", vt[0] - acc, DELAY);
    for (int i = 1; i < 5; i++) chk(vt[i] - vt[i-1] == PERIOD, "R4 spacing", vt[i] - vt[i-1], PERIOD);
    for (int i = 0; i < 3; i++) chk(vr[i] == 1 && vd[i] == 16'hA001 + i, "R6 real order", vd[i], 16'hA001 + i);
    for (int i = 3; i < 5; i++) chk(vr[i] == 0 && vd[i] == 0, "R5 dummy", vd[i], 0);

    // overfill: 10 pushes, 8 kept
    clr();
    for (int i = 0; i < 10; i++) push(16'hB000 + i);
    chk(full == 1, "R7 full flag", full, 1);
    chk(occ == DEPTH, "R7 occ at limit", occ, DEPTH);
    req(9, acc);
    repeat (50) @(negedge clk);
    chk(vt.size() == 9, "R2 word count 9", vt.size(), 9);
    for (int i = 0; i < 8; i++) chk(vd[i] == 16'hB000 + i, "R7 kept words", vd[i], 16'hB000 + i);
    chk(vr[8] == 0, "R7 dropped pushes not stored", vr[8], 0);

    // back-to-back requests
    clr();
    req(2, acc);
    req(3, acc2);
    repeat (40) @(negedge clk);
    chk(vt.size() == 5, "R9 total words", vt.size(), 5);
    chk(vt[0] - acc == DELAY, "R9 first start", vt[0] - acc, DELAY);
    chk(vt[2] - vt[1] == PERIOD, "R9 second waits for first", vt[2] - vt[1], PERIOD);
    chk(vt[2] - acc2 > DELAY, "R9 second after own delay", vt[2] - acc2, DELAY + 1);

    // zero-size request
    clr();
    req(0, acc);
    repeat (30) @(negedge clk);
    chk(vt.size() == 0, "R10 zero size silent", vt.size(), 0);

    // request queue overflow
    clr();
    for (int i = 0; i < 5; i++) begin
      req(1, acc);
      if (i == 3) chk(req_ready == 0, "R11 queue full", req_ready, 0);
    end
    repeat (40) @(negedge clk);
    chk(vt.size() == 4, "R11 fifth request dropped", vt.size(), 4);

    // fill independence
    clr();
    req(4, acc);
    repeat (30) @(negedge clk);
    for (int i = 0; i < vt.size(); i++) rel0.push_back(vt[i] - acc);
    clr();
    for (int i = 0; i < DEPTH; i++) push(16'hC000 + i);
    req(4, acc);
    repeat (30) @(negedge clk);
    chk(vt.size() == rel0.size(), "R12 same count", vt.size(), rel0.size());
    for (int i = 0; i < vt.size() && i < rel0.size(); i++)
      chk(vt[i] - acc == rel0[i], "R12 same timing", vt[i] - acc, rel0[i]);

    done = 1;
    summary();
  end
endmodule